// File: doc/BRIEF.md
# Thread Context Run-State Controller

This block keeps the run state of a fixed number of hardware thread contexts in a multithreaded or multiprocessor core. Each context has its own set of command strobes: start running after a programmable number of cycles, pause, release the context, or shut it down for good. For every context the block reports a 2-bit state code and an execute-enable that allows the instruction pipeline to issue for that context. A single global flag goes high once every context has shut down, so the surrounding system can terminate.

Each context holds a small countdown. A start request loads the countdown, and the context enters the running state only when the countdown expires. A pause, release or shutdown issued while a countdown is in progress cancels it. A context that has shut down stays shut down until reset and ignores every later command.

Top module: `thread_run_ctrl`

## Requirements
- R1: After reset every context reports state code 0 (Unallocated), every execute-enable is low and the all-halted flag is low.
- R2: State codes are 2 bits wide: 0 Unallocated, 1 Active, 2 Suspended, 3 Halted. Context i occupies bits [2i+1:2i] of `ctx_state`, and its delay occupies bits [DLY_W*i+DLY_W-1:DLY_W*i] of `act_delay`.
- R3: A start request with delay d>0, sampled at clock edge E, moves the context to Active at edge E+d. Until that edge the context keeps its previous state.
- R4: A start request with delay 0 behaves exactly like a delay of 1.
- R5: `exec_en[i]` is high exactly when context i reports state code 1.
- R6: A pause request moves a context that is not Halted to Suspended at the next edge. A later start request brings a Suspended context back to Active after its delay.
- R7: A release request moves a context that is not Halted to Unallocated at the next edge.
- R8: A shutdown request moves a context to Halted at the next edge. A Halted context stays Halted and ignores start, pause and release requests.
- R9: When several commands reach one context in the same cycle, shutdown wins over release, release over pause, and pause over start.
- R10: Pause, release or shutdown given while a countdown is pending cancels it, so the context does not become Active later.
- R11: `all_halted` is high in the same cycle in which every context reports Halted, and is low otherwise.
- R12: Commands to one context do not change the state of any other context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_req | input | NUM_CTX | Start request for each context |
| act_delay | input | NUM_CTX*DLY_W | Start delay in cycles for each context |
| susp_req | input | NUM_CTX | Pause request for each context |
| free_req | input | NUM_CTX | Release request for each context |
| halt_req | input | NUM_CTX | Shutdown request for each context |
| ctx_state | output | 2*NUM_CTX | Current state code of each context |
| exec_en | output | NUM_CTX | Execution allowed for each context |
| all_halted | output | 1 | Every context has shut down |

## Verification
A wrong internal state shows at the ports right away, because the state code is the register itself and the execute-enable and all-halted flag are decoded from it. A corrupted countdown is the case that stays hidden longest. It shows only at the edge where activation was due, either as an early or late rise of the execute-enable or, if a cancel failed, as an Active state appearing after a pause or release. The bench therefore sweeps every delay value on every context and samples the state in each cycle of the wait, including the cycle just before the expected transition.

// File: rtl/thread_ctx_pkg.sv
package thread_ctx_pkg;

   // R2: state codes seen on the ctx_state port
   typedef enum logic [1:0] {
      CTX_UNALLOC = 2'd0,
      CTX_ACTIVE  = 2'd1,
      CTX_SUSP    = 2'd2,
      CTX_HALTED  = 2'd3
   } ctx_state_e;

   localparam int unsigned CTX_STATE_W = 2;

   // decoded command for one cycle after priority resolution
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_START = 3'd1,
      OP_PAUSE = 3'd2,
      OP_FREE  = 3'd3,
      OP_STOP  = 3'd4
   } ctx_op_e;

endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
   import thread_ctx_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic             susp_i,
   input  logic             free_i,
   input  logic             halt_i,
   output ctx_state_e       state_o,
   output logic             exec_en_o
);

   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   ctx_state_e       st_q;
   logic             pend_q;
   logic [DLY_W-1:0] cnt_q;
   ctx_op_e          op;
   logic [DLY_W-1:0] load_val;

   // R9: priority stop > free > pause > start
   always_comb begin
      if (halt_i)      op = OP_STOP;
      else if (free_i) op = OP_FREE;
      else if (susp_i) op = OP_PAUSE;
      else if (act_i)  op = OP_START;
      else             op = OP_NONE;
   end

   // R4: a zero delay is raised to one cycle
   assign load_val = (dly_i == '0) ? ONE : dly_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CTX_UNALLOC;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (st_q != CTX_HALTED) begin
         unique case (op)
            OP_STOP: begin
               st_q   <= CTX_HALTED;
               pend_q <= 1'b0;
            end
            OP_FREE: begin
               st_q   <= CTX_UNALLOC;
               pend_q <= 1'b0;
            end
            OP_PAUSE: begin
               st_q   <= CTX_SUSP;
               pend_q <= 1'b0;
            end
            OP_START: begin
               pend_q <= 1'b1;
               cnt_q  <= load_val;
            end
            default: begin
               if (pend_q) begin
                  if (cnt_q == ONE) begin
                     st_q   <= CTX_ACTIVE;
                     pend_q <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q - ONE;
                  end
               end
            end
         endcase
      end
   end

   assign state_o   = st_q;
   assign exec_en_o = (st_q == CTX_ACTIVE);

   // R8
   halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == CTX_HALTED |=> st_q == CTX_HALTED);

   // R8
   stop_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> st_q == CTX_HALTED);

   // R7
   free_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_i && !halt_i && st_q != CTX_HALTED) |=> st_q == CTX_UNALLOC);

   // R3
   act_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exec_en_o) |-> $past(pend_q));

   // R4
   pend_cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> cnt_q != '0);

endmodule

// File: rtl/halt_reduce.sv
module halt_reduce #(
   parameter int unsigned NUM_CTX = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CTX-1:0] halted_i,
   output logic               all_o
);

   assign all_o = &halted_i;

   // R11: once every context is halted the flag never drops
   all_halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_o |=> all_o);

endmodule

// File: rtl/thread_run_ctrl.sv
module thread_run_ctrl
   import thread_ctx_pkg::*;
#(
   parameter int unsigned NUM_CTX = 4,
   parameter int unsigned DLY_W   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CTX-1:0]         act_req,
   input  logic [NUM_CTX*DLY_W-1:0]   act_delay,
   input  logic [NUM_CTX-1:0]         susp_req,
   input  logic [NUM_CTX-1:0]         free_req,
   input  logic [NUM_CTX-1:0]         halt_req,
   output logic [NUM_CTX*2-1:0]       ctx_state,
   output logic [NUM_CTX-1:0]         exec_en,
   output logic                       all_halted
);

   localparam int unsigned SW = CTX_STATE_W;

   generate
      if (NUM_CTX < 1) begin : g_bad_ctx
         $error("thread_run_ctrl: NUM_CTX must be at least 1");
      end
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
         $error("thread_run_ctrl: DLY_W must lie in 1..16");
      end
   endgenerate

   logic [NUM_CTX-1:0] halted;

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      ctx_state_e st;

      ctx_slot #(.DLY_W(DLY_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .act_i     (act_req[i]),
         .dly_i     (act_delay[i*DLY_W +: DLY_W]),
         .susp_i    (susp_req[i]),
         .free_i    (free_req[i]),
         .halt_i    (halt_req[i]),
         .state_o   (st),
         .exec_en_o (exec_en[i])
      );

      assign ctx_state[i*SW +: SW] = st;
      assign halted[i]             = (st == CTX_HALTED);

      // R5
      exec_en_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         exec_en[i] |-> ctx_state[i*SW +: SW] == 2'd1);
   end

   halt_reduce #(.NUM_CTX(NUM_CTX)) u_term (
      .clk      (clk),
      .rst_n    (rst_n),
      .halted_i (halted),
      .all_o    (all_halted)
   );

endmodule

// File: tb/sim_thread_run_ctrl.sv
`timescale 1ns/1ps
module sim_thread_run_ctrl;

   localparam int N = 4;
   localparam int W = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   act_req = '0;
   logic [N*W-1:0] act_delay = '0;
   logic [N-1:0]   susp_req = '0;
   logic [N-1:0]   free_req = '0;
   logic [N-1:0]   halt_req = '0;
   logic [N*2-1:0] ctx_state;
   logic [N-1:0]   exec_en;
   logic           all_halted;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   thread_run_ctrl #(.NUM_CTX(N), .DLY_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_delay(act_delay),
      .susp_req(susp_req), .free_req(free_req), .halt_req(halt_req),
      .ctx_state(ctx_state), .exec_en(exec_en), .all_halted(all_halted)
   );

   function automatic int st_of(input int c);
      return int'(ctx_state[c*2 +: 2]);
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   task automatic cmd(input int c, input bit a, input bit s, input bit f,
                      input bit h, input int d);
      @(negedge clk);
      act_req[c]  = a;
      susp_req[c] = s;
      free_req[c] = f;
      halt_req[c] = h;
      act_delay[c*W +: W] = W'(d);
      @(negedge clk);
      act_req = '0; susp_req = '0; free_req = '0; halt_req = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      for (int c = 0; c < N; c++) begin
         chk($sformatf("R1 state ctx%0d", c), st_of(c), 0);
         chk($sformatf("R1 exec ctx%0d", c), int'(exec_en[c]), 0);
      end
      chk("R1 all_halted", int'(all_halted), 0);

      // R3 R4 R5 R6 R12 delay sweep on every context
      for (int c = 0; c < N; c++) begin
         for (int d = 0; d < (1 << W); d++) begin
            int eff;
            eff = (d == 0) ? 1 : d;
            cmd(c, 0, 0, 1, 0, 0);
            chk("R7 free to unalloc", st_of(c), 0);
            cmd(c, 1, 0, 0, 0, d);
            for (int k = 0; k <= eff; k++) begin
               if (k > 0) @(negedge clk);
               if (k < eff) begin
                  chk($sformatf("R3 R4 wait ctx%0d d%0d k%0d", c, d, k), st_of(c), 0);
                  chk("R5 exec low while waiting", int'(exec_en[c]), 0);
               end else begin
                  chk($sformatf("R3 R4 active ctx%0d d%0d", c, d), st_of(c), 1);
                  chk("R5 exec high when active", int'(exec_en[c]), 1);
               end
            end
            for (int o = 0; o < N; o++)
               if (o != c) chk($sformatf("R12 other ctx%0d", o), st_of(o), (o < c) ? 2 : 0);
            cmd(c, 0, 1, 0, 0, 0);
            chk("R6 pause", st_of(c), 2);
            chk("R5 exec low when paused", int'(exec_en[c]), 0);
         end
      end

      // R6 reactivation from Suspended
      cmd(0, 1, 0, 0, 0, 2);
      chk("R6 still paused", st_of(0), 2);
      idle(1);
      chk("R6 paused one cycle in", st_of(0), 2);
      idle(1);
      chk("R6 reactivated", st_of(0), 1);

      // R10 cancel by pause
      cmd(2, 0, 0, 1, 0, 0);
      cmd(2, 1, 0, 0, 0, 5);
      idle(1);
      cmd(2, 0, 1, 0, 0, 0);
      idle(8);
      chk("R10 pause cancels", st_of(2), 2);
      // R10 cancel by release
      cmd(2, 1, 0, 0, 0, 4);
      cmd(2, 0, 0, 1, 0, 0);
      idle(6);
      chk("R10 release cancels", st_of(2), 0);
      chk("R10 exec stays low", int'(exec_en[2]), 0);

      // R9 priority on ctx1 (currently Suspended)
      cmd(1, 1, 1, 1, 0, 1);
      chk("R9 release over pause/start", st_of(1), 0);
      idle(3);
      chk("R9 no late start", st_of(1), 0);
      cmd(1, 1, 1, 0, 0, 1);
      chk("R9 pause over start", st_of(1), 2);
      idle(3);
      chk("R9 pause keeps", st_of(1), 2);
      cmd(1, 1, 1, 1, 1, 1);
      chk("R9 R8 stop wins", st_of(1), 3);

      // R8 Halted ignores everything
      cmd(1, 1, 0, 0, 0, 1);
      cmd(1, 0, 1, 0, 0, 0);
      cmd(1, 0, 0, 1, 0, 0);
      idle(3);
      chk("R8 halted sticky", st_of(1), 3);
      chk("R8 exec low", int'(exec_en[1]), 0);
      chk("R11 one halted", int'(all_halted), 0);

      // R11 all-halted detection
      cmd(0, 0, 0, 0, 1, 0);
      chk("R8 ctx0 halted", st_of(0), 3);
      chk("R11 two halted", int'(all_halted), 0);
      cmd(2, 0, 0, 0, 1, 0);
      chk("R11 three halted", int'(all_halted), 0);
      cmd(3, 0, 0, 0, 1, 0);
      chk("R8 ctx3 halted", st_of(3), 3);
      chk("R11 all halted", int'(all_halted), 1);
      cmd(3, 0, 0, 1, 0, 0);
      chk("R11 stays", int'(all_halted), 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule